// File: doc/BRIEF.md
# ADC Conversion Clock Prescaler with Timebase Ticks

This block produces the clock enables that pace an analog-to-digital converter. It divides the system clock down to a converter-clock enable. From that enable it derives two slower periodic strobes, a short one and a long one, which control settling and sampling intervals. All outputs are single-cycle enables in the system clock domain. No derived clock is generated.

A single 32-bit divider word programs the block. Each 8-bit field holds its divide ratio minus one. The main field counts system clocks. The two tick fields count main-enable pulses, so the three dividers form a cascade. Software picks the main ratio so that the converter clock stays inside its allowed range; the block only applies the programmed ratio and does not check it. Every write to the word restarts all three dividers from a clean phase.

Top module: `adc_tick_gen`

## Requirements
- R1: After synchronous reset the divider word is zero, and `main_en`, `short_tick` and `long_tick` are all high on every cycle.
- R2: With main field M in bits [7:0], `main_en` is a one-cycle pulse that is high once every M+1 system cycles (ratios 1 to 256).
- R3: With short field S in bits [15:8], `short_tick` is high on every (S+1)-th `main_en` pulse.
- R4: With long field L in bits [23:16], `long_tick` is high on every (L+1)-th `main_en` pulse.
- R5: A field value of 0 divides by one: its output is high on every enable at its input.
- R6: A write restarts all counters. The first `main_en` comes on the (M+1)-th cycle after the write edge, and the tick counts restart from zero pulses.
- R7: Bits [31:24] of the written word have no effect on any output.
- R8: `short_tick` and `long_tick` are only ever high in a cycle where `main_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the divider word |
| cfg_wdata | input | 32 | Divider word: [7:0] main, [15:8] short, [23:16] long, each the ratio minus one |
| main_en | output | 1 | Converter clock enable pulse |
| short_tick | output | 1 | Short-interval strobe |
| long_tick | output | 1 | Long-interval strobe |

## Verification
A corrupted main counter shows within one main period. `main_en` then comes early or late relative to the last write or pulse. A wrong tick counter appears as a misplaced strobe no later than the (S+1)-th or (L+1)-th main pulse, so with large fields it can take many thousands of cycles to show. The bench restarts the phase with writes made in mid-count and predicts each cycle of all three outputs from the written fields alone. This exposes any counter that a write fails to clear, or a field decoded from the wrong bits, within the first period after the write.

// File: rtl/adc_tick_pkg.sv
package adc_tick_pkg;

    localparam int FIELD_W = 8;
    localparam int REG_W   = 32;
    localparam int N_TICKS = 2;

    typedef struct packed {
        logic [FIELD_W-1:0] long_m1;
        logic [FIELD_W-1:0] short_m1;
        logic [FIELD_W-1:0] main_m1;
    } div_cfg_t;

    function automatic div_cfg_t decode_word(input logic [REG_W-1:0] w);
        div_cfg_t c;
        c.main_m1  = w[FIELD_W-1:0];
        c.short_m1 = w[2*FIELD_W-1:FIELD_W];
        c.long_m1  = w[3*FIELD_W-1:2*FIELD_W];
        return c;
    endfunction

endpackage

// File: rtl/adc_div_regs.sv
module adc_div_regs
    import adc_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output div_cfg_t         cfg,
    output logic             restart
);
    div_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= decode_word(wdata);
        end
    end

    assign cfg     = cfg_q;
    assign restart = we;
endmodule

// File: rtl/adc_en_div.sv
module adc_en_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         in_en,
    input  logic [W-1:0] ratio_m1,
    output logic         out_en
);
    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == ratio_m1);
    assign out_en = in_en && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (in_en) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
    import adc_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic             main_en,
    output logic             short_tick,
    output logic             long_tick
);
    div_cfg_t           cfg;
    logic               restart;
    logic [FIELD_W-1:0] tick_ratio [N_TICKS];
    logic               tick_out   [N_TICKS];

    adc_div_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .cfg     (cfg),
        .restart (restart)
    );

    adc_en_div #(.W(FIELD_W)) u_main_div (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart),
        .in_en    (1'b1),
        .ratio_m1 (cfg.main_m1),
        .out_en   (main_en)
    );

    assign tick_ratio[0] = cfg.short_m1;
    assign tick_ratio[1] = cfg.long_m1;

    for (genvar g = 0; g < N_TICKS; g++) begin : g_tick
        adc_en_div #(.W(FIELD_W)) u_tick_div (
            .clk      (clk),
            .rst      (rst),
            .clr      (restart),
            .in_en    (main_en),
            .ratio_m1 (tick_ratio[g]),
            .out_en   (tick_out[g])
        );
    end

    assign short_tick = tick_out[0];
    assign long_tick  = tick_out[1];
endmodule

// File: rtl/adc_tick_gen_chk.sv
module adc_tick_gen_chk
    import adc_tick_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_wdata,
    input logic             main_en,
    input logic             short_tick,
    input logic             long_tick
);
    logic [FIELD_W-1:0] sh_m, sh_s;
    logic [FIELD_W-1:0] gap_m, cnt_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_m  <= '0;
            sh_s  <= '0;
            gap_m <= '0;
            cnt_s <= '0;
        end else if (cfg_we) begin
            sh_m  <= cfg_wdata[FIELD_W-1:0];
            sh_s  <= cfg_wdata[2*FIELD_W-1:FIELD_W];
            gap_m <= '0;
            cnt_s <= '0;
        end else begin
            gap_m <= main_en ? '0 : gap_m + 1'b1;
            if (short_tick)   cnt_s <= '0;
            else if (main_en) cnt_s <= cnt_s + 1'b1;
        end
    end

    // R1: all enables high in the first cycle after reset
    a_r1_reset_all_high: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (main_en && short_tick && long_tick));

    // R2: main enable exactly on the programmed period
    a_r2_main_period: assert property (@(posedge clk) disable iff (rst)
        main_en == (gap_m == sh_m));

    // R3: short strobe on the (S+1)-th main pulse
    a_r3_short_count: assert property (@(posedge clk) disable iff (rst)
        main_en |-> (short_tick == (cnt_s == sh_s)));

    // R6: a write with a nonzero main field suppresses the next cycle's enable
    a_r6_write_restarts: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[FIELD_W-1:0] != '0) |=> !main_en);

    // R8: strobes only alongside the main enable
    a_r8_short_needs_main: assert property (@(posedge clk) disable iff (rst)
        short_tick |-> main_en);
    a_r8_long_needs_main: assert property (@(posedge clk) disable iff (rst)
        long_tick |-> main_en);
endmodule

bind adc_tick_gen adc_tick_gen_chk i_chk (.*);

// File: tb/test_adc_tick_gen.sv
module test_adc_tick_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        main_en, short_tick, long_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        bit    m;
        bit    s;
        bit    l;
        string tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    adc_tick_gen i_adc_tick_gen (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .main_en    (main_en),
        .short_tick (short_tick),
        .long_tick  (long_tick)
    );

    task automatic cmp(input bit act, input bit exp, input string what, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // monitor: pops one expectation per cycle, sampled at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(main_en,    e.m, "main_en (R2)",    e.tag);
            cmp(short_tick, e.s, "short_tick (R3)", e.tag);
            cmp(long_tick,  e.l, "long_tick (R4)",  e.tag);
        end
    end

    // expected outputs for n cycles following a clean phase start
    task automatic push_model(input int mf, input int sf, input int lf, input int n, input string tag);
        for (int t = 0; t < n; t++) begin
            exp_t e;
            int   k;
            e.m = ((t + 1) % (mf + 1)) == 0;
            k   = (t + 1) / (mf + 1);
            e.s = e.m && (k % (sf + 1) == 0);
            e.l = e.m && (k % (lf + 1) == 0);
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic program_run(input logic [31:0] w, input int n, input string tag);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(posedge clk);
        push_model(int'(w[7:0]), int'(w[15:8]), int'(w[23:16]), n, tag);
        @(negedge clk);
        cfg_we = 1'b0;
        wait (q.size() == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        push_model(0, 0, 0, 8, "R1");
        wait (q.size() == 0);

        program_run(32'h0004_0103, 80, "R2 R3 R4 R8");
        program_run(32'h0002_0000, 12, "R5");
        program_run(32'hFF00_0205, 60, "R7");
        program_run(32'h0000_0007, 5,  "R6 partial");
        program_run(32'h0001_0102, 30, "R6");
        program_run(32'h0001_01FF, 1100, "R2 max ratio");
        program_run(32'h0003_0201, 40, "R6 R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule